// File: doc/BRIEF.md
# Flash Erase Status Byte Generator

This block sits on the device side of a parallel NOR flash model and decides what a bus read returns while an erase is under way. An abstract erase engine supplies its progress: whether an erase is active, whether the internal erase has really begun, whether it is suspended, whether it has failed, which blocks are selected for erase, and which of those failed. For every read strobe, the block returns either a status byte or the array data supplied on an input, chosen by the addressed block and the engine state.

The status byte carries two independent toggle bits. Bit 6 flips on each read inside a selected block while erasing. Bit 2 flips on reads inside a selected block while erasing or suspended. After an error, bit 2 flips only for blocks that failed. Bit 3 shows whether erasing has begun. Bit 5 shows the error. The memory is split into uniform blocks, and the block index is taken from the top address bits. The outcome of each read is registered and appears one clock after the strobe.

Top module: `flash_erase_status`

## Requirements
- R1: During and immediately after reset, `rd_valid` is 0, `rd_data` is 0 and both toggle states are 0.
- R2: Every read strobe yields `rd_valid`=1 for exactly one cycle, one clock later. When `erase_active`=0, `rd_data` equals the `array_data` sampled with the strobe.
- R3: In a status byte, bit 7 is 0, bit 5 equals `erase_error`, and bits 4, 1 and 0 are 0.
- R4: Status bit 3 equals `erase_started`. It is 0 in the window before erasing begins, while more blocks may still be added to `sel_mask`, and 1 afterwards.
- R5: While `erase_active`=1 and `suspend`=0, each read of an address in a block whose `sel_mask` bit is 1 returns the current bit 6 and then inverts it.
- R6: With no error, each read of a selected block while `erase_active`=1 returns the current bit 2 and then inverts it. This applies whether or not the erase is suspended.
- R7: While erasing and not suspended, a read of a block outside `sel_mask` returns the status byte and leaves both toggle states unchanged.
- R8: While suspended, reads of blocks outside `sel_mask` return `array_data`. Reads of selected blocks return status, with bit 2 inverting and bit 6 held.
- R9: With `erase_error`=1, bit 2 inverts only on reads of selected blocks whose `fail_mask` bit is 1. For selected blocks that passed, bit 2 stays constant. Bit 6 still follows R5.
- R10: A rising edge of `erase_active` clears both toggle states, so the first status read of each operation shows 0 on bits 6 and 2.
- R11: The block index is `rd_addr[ADDR_W-1 -: log2(NBLK)]`. The lower address bits do not affect block selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| erase_active | input | 1 | Erase operation in progress (including suspend) |
| erase_started | input | 1 | Internal erasing has begun |
| suspend | input | 1 | Erase is suspended |
| erase_error | input | 1 | Erase reported a failure |
| sel_mask | input | NBLK | Blocks selected for erase |
| fail_mask | input | NBLK | Blocks that failed to erase |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | 8 | Memory cell data for the read address |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Status byte or array data |

## Verification
Each read result is due on the first rising edge after the strobe is sampled. Any toggle change caused by that read shows up only in the result of the next status read. The driver raises a strobe on a falling edge and records the expected byte in a queue at that moment. The monitor compares on each later falling edge where `rd_valid` is high, which is exactly one clock after the strobe. Changes to the engine inputs are applied on falling edges between reads, so each strobe sees one settled engine state.

// File: rtl/fes_pkg.sv
package fes_pkg;
    localparam int BYTE_W = 8;

    // bit positions inside the status byte
    localparam int POS_POLL  = 7;
    localparam int POS_TOG   = 6;
    localparam int POS_ERR   = 5;
    localparam int POS_TIMER = 3;
    localparam int POS_ALT   = 2;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              act;
    } fes_out_t;
endpackage

// File: rtl/fes_blk_lookup.sv
module fes_blk_lookup #(
    parameter int NBLK  = 8,
    parameter int BLK_W = $clog2(NBLK)
) (
    input  logic [BLK_W-1:0] blk_idx,
    input  logic [NBLK-1:0]  sel_mask,
    input  logic [NBLK-1:0]  fail_mask,
    output logic             in_sel,
    output logic             in_fail
);
    logic [NBLK-1:0] hit;

    generate
        for (genvar g = 0; g < NBLK; g++) begin : g_dec
            assign hit[g] = (blk_idx == BLK_W'(g));
        end
    endgenerate

    assign in_sel  = |(hit & sel_mask);
    assign in_fail = |(hit & sel_mask & fail_mask);
endmodule

// File: rtl/fes_toggle_bit.sv
module fes_toggle_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic cur
);
    logic q_d, q_q;

    always_comb begin
        cur = clr ? 1'b0 : q_q;
        q_d = step ? ~cur : cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= q_d;
    end

    AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(q_q)); // R7
    AST_TOG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !step) |=> (q_q == 1'b0)); // R10
endmodule

// File: rtl/flash_erase_status.sv
module flash_erase_status
    import fes_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int NBLK   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_active,
    input  logic              erase_started,
    input  logic              suspend,
    input  logic              erase_error,
    input  logic [NBLK-1:0]   sel_mask,
    input  logic [NBLK-1:0]   fail_mask,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] array_data,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int BLK_W = $clog2(NBLK);
    localparam int TOG_N = 2;   // index 0: bit 6, index 1: bit 2

    fes_out_t st_d, st_q;

    logic             in_sel, in_fail;
    logic             start_pulse;
    logic             show_status;
    logic [TOG_N-1:0] tog_step, tog_cur;
    logic [BYTE_W-1:0] status_byte;

    fes_blk_lookup #(.NBLK(NBLK), .BLK_W(BLK_W)) u_lookup (
        .blk_idx  (rd_addr[ADDR_W-1 -: BLK_W]),
        .sel_mask (sel_mask),
        .fail_mask(fail_mask),
        .in_sel   (in_sel),
        .in_fail  (in_fail)
    );

    assign start_pulse = erase_active && !st_q.act;
    assign tog_step[0] = rd_en && erase_active && !suspend && in_sel;
    assign tog_step[1] = rd_en && erase_active && in_sel && (!erase_error || in_fail);

    generate
        for (genvar t = 0; t < TOG_N; t++) begin : g_tog
            fes_toggle_bit u_tog (
                .clk  (clk),
                .rst_n(rst_n),
                .clr  (start_pulse),
                .step (tog_step[t]),
                .cur  (tog_cur[t])
            );
        end
    endgenerate

    always_comb begin
        status_byte            = '0;
        status_byte[POS_POLL]  = 1'b0;
        status_byte[POS_TOG]   = tog_cur[0];
        status_byte[POS_ERR]   = erase_error;
        status_byte[POS_TIMER] = erase_started;
        status_byte[POS_ALT]   = tog_cur[1];

        show_status = erase_active && (!suspend || in_sel);

        st_d       = st_q;
        st_d.act   = erase_active;
        st_d.valid = rd_en;
        if (rd_en)
            st_d.data = show_status ? status_byte : array_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.valid;
    assign rd_data  = st_q.data;

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R2
    AST_IDLE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !erase_active) |=> (rd_data == $past(array_data))); // R2
    AST_STATUS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && erase_active && !suspend) |=>
        (rd_data[7] == 1'b0 && rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00)); // R3
    AST_ERR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && erase_active && !suspend) |=> (rd_data[5] == $past(erase_error))); // R3
    AST_TIMER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && erase_active && !suspend) |=> (rd_data[3] == $past(erase_started))); // R4
    AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && start_pulse && !suspend) |=> (rd_data[6] == 1'b0 && rd_data[2] == 1'b0)); // R10
endmodule

// File: tb/flash_erase_status_test.sv
`timescale 1ns/1ps
module flash_erase_status_test;
    localparam int ADDR_W = 19;
    localparam int NBLK   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              erase_active = 1'b0, erase_started = 1'b0;
    logic              suspend = 1'b0, erase_error = 1'b0;
    logic [NBLK-1:0]   sel_mask = '0, fail_mask = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        array_data;
    logic              rd_valid;
    logic [7:0]        rd_data;

    always #2 clk = ~clk;   // 250 MHz

    assign array_data = rd_addr[7:0] ^ rd_addr[15:8] ^ 8'h5A;

    flash_erase_status #(.ADDR_W(ADDR_W), .NBLK(NBLK)) uut (
        .clk(clk), .rst_n(rst_n),
        .erase_active(erase_active), .erase_started(erase_started),
        .suspend(suspend), .erase_error(erase_error),
        .sel_mask(sel_mask), .fail_mask(fail_mask),
        .rd_en(rd_en), .rd_addr(rd_addr), .array_data(array_data),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic m6 = 1'b0, m2 = 1'b0;   // bench model of the toggle states

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic engine(input logic act, input logic st, input logic sus,
                          input logic err, input logic [NBLK-1:0] sel,
                          input logic [NBLK-1:0] fl);
        if (act && !erase_active) begin m6 = 1'b0; m2 = 1'b0; end   // R10
        erase_active = act; erase_started = st; suspend = sus;
        erase_error = err; sel_mask = sel; fail_mask = fl;
    endtask

    task automatic do_read(input logic [2:0] blk, input logic [15:0] low, input string tag);
        logic [ADDR_W-1:0] a;
        logic [7:0] exp;
        logic s;
        a = {blk, low};   // R11: block index from the top address bits
        s = sel_mask[blk];
        if (!erase_active || (suspend && !s))
            exp = a[7:0] ^ a[15:8] ^ 8'h5A;
        else begin
            exp = {1'b0, m6, erase_error, 1'b0, erase_started, m2, 2'b00};
            if (!suspend && s) m6 = ~m6;
            if (s && (!erase_error || fail_mask[blk])) m2 = ~m2;
        end
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check("R2 unexpected valid", 8'h01, 8'h00);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset valid", {7'd0, rd_valid}, 8'h00);
        check("R1 reset data", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset valid", {7'd0, rd_valid}, 8'h00);

        // R2 idle reads, back to back
        do_read(3'd1, 16'h1234, "R2 idle blk1");
        do_read(3'd6, 16'hABCD, "R2 idle blk6");
        @(negedge clk);
        check("R2 single-cycle valid", {7'd0, rd_valid}, 8'h00);

        // block erase of blocks 0 and 2, timer window open
        engine(1, 0, 0, 0, 8'b0000_0101, 8'h00);
        do_read(3'd0, 16'h0010, "R10 R4 R3 first status");
        do_read(3'd2, 16'h0020, "R5 R6 second status");
        do_read(3'd5, 16'h0030, "R7 unselected status");
        do_read(3'd5, 16'h0031, "R7 unselected again");
        engine(1, 0, 0, 0, 8'b0010_0101, 8'h00);   // block 5 added in window
        do_read(3'd5, 16'h0032, "R4 R5 added block");
        engine(1, 1, 0, 0, 8'b0010_0101, 8'h00);
        do_read(3'd0, 16'hFFFF, "R4 timer set");
        do_read(3'd2, 16'h0000, "R5 R6 toggle");
        do_read(3'd3, 16'h0040, "R7 R3 unselected");

        // suspend
        engine(1, 1, 1, 0, 8'b0010_0101, 8'h00);
        do_read(3'd3, 16'h0050, "R8 array during suspend");
        do_read(3'd0, 16'h0060, "R8 bit6 held bit2 toggles");
        do_read(3'd2, 16'h0070, "R8 R6 suspend toggle");
        do_read(3'd7, 16'h0080, "R8 array blk7");

        // resume with error; block 2 failed
        engine(1, 1, 0, 1, 8'b0010_0101, 8'b0000_0100);
        do_read(3'd0, 16'h0090, "R9 R3 passed block");
        do_read(3'd0, 16'h0091, "R9 passed block constant");
        do_read(3'd2, 16'h00A0, "R9 failed block toggles");
        do_read(3'd2, 16'h00A1, "R9 failed block again");
        do_read(3'd4, 16'h00B0, "R9 R7 unselected");

        // done: back to read mode
        engine(0, 0, 0, 0, 8'h00, 8'h00);
        do_read(3'd2, 16'h00C0, "R2 after completion");

        // new erase on block 7, checked at both address extremes
        engine(1, 1, 0, 0, 8'h80, 8'h00);
        do_read(3'd7, 16'hFFFF, "R10 R11 new op first read");
        do_read(3'd7, 16'h0000, "R11 R5 low bits ignored");
        do_read(3'd6, 16'hFFFF, "R11 R7 neighbour block");

        repeat (3) @(negedge clk);
        check("R2 all results returned", 8'(exp_q.size()), 8'h00);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule